// File: doc/BRIEF.md
# Set-Associative Cache Tag Array

This block does the lookup and replacement for a small set-associative cache. It works on block numbers, so the byte offset is already removed. It stores only tags, valid bits and per-set replacement state. Each accepted request selects one set. The set index is the block number modulo the number of sets. The block compares the stored tags of every way in that set at the same time and reports whether the block is present. On a hit it returns the matching way. On a miss it claims a way for the new block and returns that way, so the surrounding cache knows where the refill goes. The data payload, refill timing and write policy belong to the surrounding cache.

Associativity is a parameter. A setting of one way gives a direct-mapped array, where each block has exactly one possible location. A setting equal to the entry count gives a single fully associative set. Replacement is true least-recently-used within each set. It uses one age value per way: a hit or an allocation makes that way the youngest, and the oldest way is the eviction candidate. A synchronous flush input invalidates every entry. Requests are refused while it is high.

Top module: `ctag_array`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is 0 and `req_ready` is 1. The first reference to any block reports a miss.
- R2: The set is `req_blk % SETS` and the tag is `req_blk / SETS`. A block allocated in one set neither hits in another set nor displaces that set's entries.
- R3: A request hits when a valid way of its set holds its tag. `rsp_hit` is then 1 and `rsp_way` gives that way's number (0 to WAYS-1).
- R4: At most one way of a set matches any request.
- R5: On a miss, if the set has an invalid way, the lowest-numbered invalid way is allocated and reported on `rsp_way`.
- R6: On a miss in a full set, the least recently used way is evicted and reported. Both hits and allocations make the accessed way the most recently used.
- R7: With WAYS=1 and 2 entries, the block sequence 0,4,0,4,... misses on every reference, always in way 0.
- R8: With WAYS equal to ENTRIES, any block can occupy any way. With 4 ways, blocks 0,1,2,3 fill ways 0,1,2,3, and all of them then hit.
- R9: A request is accepted when `req_valid` and `req_ready` are both 1. Its result appears on `rsp_valid`/`rsp_hit`/`rsp_way` exactly one cycle later, and `rsp_valid` is 1 only in such a cycle.
- R10: While `flush` is 1, `req_ready` is 0 and no request is accepted. After a flush cycle every entry is invalid, so the next references miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries; blocks requests |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (low during flush) |
| req_blk | input | BLK_W | Block number to look up |
| rsp_valid | output | 1 | Result of the request accepted last cycle |
| rsp_hit | output | 1 | 1 = hit, 0 = miss (allocated) |
| rsp_way | output | WAY_W | Way that hit or was allocated |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any request, so that the age values of each set start as a permutation. They also assume that `req_blk` is stable while `req_valid` is high. The bench drives every input at the falling edge, starts each scenario with a flush, and issues one request every two cycles. Each response is therefore read in isolation before the next request changes the state. The flush test keeps `req_valid` high throughout the flush, which exercises the refusal path without breaking those assumptions.

// File: rtl/ctag_pkg.sv
package ctag_pkg;
  // Width of an index over n items, never less than one bit.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // Number of block-number bits consumed by the set index.
  function automatic int unsigned set_bits(input int unsigned sets);
    return (sets <= 1) ? 0 : $clog2(sets);
  endfunction

  // Set chosen by a block number.
  function automatic int unsigned blk_set(input int unsigned blk, input int unsigned sets);
    return blk % sets;
  endfunction

  // Tag kept for a block number.
  function automatic int unsigned blk_tag(input int unsigned blk, input int unsigned sets);
    return blk / sets;
  endfunction
endpackage

// File: rtl/ctag_match.sv
module ctag_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 6,
  parameter int WAY_W = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
  input  logic [WAYS-1:0]            set_vld,
  input  logic [TAG_W-1:0]           look_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic                       has_free,
  output logic [WAY_W-1:0]           free_way
);
  // One comparator per way, all working in parallel.
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = set_vld[w] && (set_tags[w] == look_tag);
  end

  assign hit      = |hit_vec;
  assign has_free = ~&set_vld;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  // Lowest invalid way: scan downward so the smallest index wins.
  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!set_vld[w]) free_way = WAY_W'(w);
  end

  // R4
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
endmodule

// File: rtl/ctag_lru.sv
module ctag_lru #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int SET_W = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [SET_W-1:0] sel_set,
  input  logic             touch,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim_way
);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
  logic [WAYS-1:0]            old_vec;
  logic [WAY_W-1:0]           touch_age;

  // Ages in every set stay a permutation of 0..WAYS-1.
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[sel_set][w] <= '0;
        else if (age_q[sel_set][w] < touch_age)
          age_q[sel_set][w] <= age_q[sel_set][w] + 1'b1;
      end
    end
  end

  assign touch_age = age_q[sel_set][touch_way];

  for (genvar w = 0; w < WAYS; w++) begin : g_old
    assign old_vec[w] = (age_q[sel_set][w] == OLDEST);
  end

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (old_vec[w]) victim_way = WAY_W'(w);
  end

  // R6
  one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n) $countones(old_vec) == 1);
  // R6
  touched_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (touch && !flush) |=> age_q[$past(sel_set)][$past(touch_way)] == '0);
endmodule

// File: rtl/ctag_array.sv
module ctag_array
  import ctag_pkg::*;
#(
  parameter int BLK_W   = 8,
  parameter int ENTRIES = 8,
  parameter int WAYS    = 2,
  localparam int SETS   = ENTRIES / WAYS,
  localparam int SET_W  = idx_width(SETS),
  localparam int TAG_W  = BLK_W - set_bits(SETS),
  localparam int WAY_W  = idx_width(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BLK_W-1:0] req_blk,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [WAY_W-1:0] rsp_way
);
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];

  logic                       accept;
  logic [SET_W-1:0]           req_set;
  logic [TAG_W-1:0]           req_tag;
  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAYS-1:0]            hit_vec;
  logic                       hit;
  logic [WAY_W-1:0]           hit_way;
  logic                       has_free;
  logic [WAY_W-1:0]           free_way;
  logic [WAY_W-1:0]           victim_way;
  logic [WAY_W-1:0]           alloc_way;
  logic                       do_alloc;

  assign req_ready = !flush;
  assign accept    = req_valid && req_ready;
  assign req_set   = SET_W'(blk_set(32'(req_blk), SETS));
  assign req_tag   = TAG_W'(blk_tag(32'(req_blk), SETS));

  always_comb begin
    for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[req_set][w];
  end

  ctag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_tags (set_tags),
    .set_vld  (vld_q[req_set]),
    .look_tag (req_tag),
    .hit_vec  (hit_vec),
    .hit      (hit),
    .hit_way  (hit_way),
    .has_free (has_free),
    .free_way (free_way)
  );

  ctag_lru #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .sel_set    (req_set),
    .touch      (accept),
    .touch_way  (alloc_way),
    .victim_way (victim_way)
  );

  // A hit refreshes its own way; a miss fills an invalid way or the oldest one.
  assign alloc_way = hit ? hit_way : (has_free ? free_way : victim_way);
  assign do_alloc  = accept && !hit;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (do_alloc) begin
      vld_q[req_set][alloc_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
    end else if (do_alloc) begin
      tag_q[req_set][alloc_way] <= req_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_hit <= hit;
        rsp_way <= alloc_way;
      end
    end
  end

  // R9
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !flush));
  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> (vld_q[req_set] == '0));
  // R5
  fill_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_alloc && has_free) |-> !vld_q[req_set][alloc_way]);
  // R3
  hit_way_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |-> hit_vec[alloc_way]);
endmodule

// File: tb/ctag_array_bench.sv
`timescale 1ns/1ps
module ctag_array_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_blk = '0;

  logic rdy_a, rdy_d, rdy_f;
  logic v_a, v_d, v_f;
  logic h_a, h_d, h_f;
  logic [0:0] w_a, w_d;
  logic [1:0] w_f;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // Main: 8 entries, 2 ways (4 sets)
  ctag_array #(.BLK_W(8), .ENTRIES(8), .WAYS(2)) u_ctag_array (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_ready(rdy_a),
    .req_blk(req_blk), .rsp_valid(v_a), .rsp_hit(h_a), .rsp_way(w_a));
  // Direct-mapped: 2 entries, 1 way
  ctag_array #(.BLK_W(8), .ENTRIES(2), .WAYS(1)) u_ctag_array_dm (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_ready(rdy_d),
    .req_blk(req_blk), .rsp_valid(v_d), .rsp_hit(h_d), .rsp_way(w_d));
  // Fully associative: 4 entries, 4 ways
  ctag_array #(.BLK_W(8), .ENTRIES(4), .WAYS(4)) u_ctag_array_fa (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_ready(rdy_f),
    .req_blk(req_blk), .rsp_valid(v_f), .rsp_hit(h_f), .rsp_way(w_f));

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // One request; the response is read one cycle after acceptance.
  task automatic issue(input int b);
    @(negedge clk);
    req_valid = 1'b1;
    req_blk   = 8'(b);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic exp_a(input string rq, input int b, input int hit, input int way);
    issue(b);
    chk({rq, " A valid"}, int'(v_a), 1);
    chk({rq, " A hit"}, int'(h_a), hit);
    chk({rq, " A way"}, int'(w_a), way);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", int'(v_a), 0);
    chk("R1 req_ready after reset", int'(rdy_a), 1);
    issue(7);
    chk("R1 first reference misses", int'(h_a), 0);
    chk("R9 rsp_valid one cycle later", int'(v_a), 1);
    @(negedge clk);
    chk("R9 rsp_valid drops when idle", int'(v_a), 0);
  endtask

  task automatic t_pingpong();
    do_flush();
    for (int i = 0; i < 8; i++) begin
      int b = (i % 2 == 0) ? 0 : 4;
      issue(b);
      chk("R7 direct-mapped ping-pong miss", int'(h_d), 0);
      chk("R7 direct-mapped way", int'(w_d), 0);
      chk("R3 two-way ping-pong hit", int'(h_a), (i >= 2) ? 1 : 0);
      chk("R5 two-way ping-pong way", int'(w_a), i % 2);
      chk("R8 full-assoc ping-pong hit", int'(h_f), (i >= 2) ? 1 : 0);
    end
  endtask

  task automatic t_sets();
    do_flush();
    exp_a("R2", 0, 0, 0);
    exp_a("R5", 4, 0, 1);
    exp_a("R2 set1", 1, 0, 0);
    exp_a("R2 set2", 2, 0, 0);
    exp_a("R2 set3", 3, 0, 0);
    exp_a("R2 set1 second way", 5, 0, 1);
    exp_a("R2 set0 untouched", 0, 1, 0);
    exp_a("R2 set1 kept", 1, 1, 0);
  endtask

  task automatic t_lru();
    do_flush();
    exp_a("R5", 0, 0, 0);
    exp_a("R5", 4, 0, 1);
    exp_a("R6 evict oldest", 8, 0, 0);
    exp_a("R6 hit refresh", 4, 1, 1);
    exp_a("R6 evict after refresh", 0, 0, 0);
    exp_a("R6 evict way1", 8, 0, 1);
  endtask

  task automatic t_fully();
    int ways [6] = '{2, 3, 0, 1, 3, 1};
    do_flush();
    for (int b = 0; b < 4; b++) begin
      issue(b);
      chk("R8 fill miss", int'(h_f), 0);
      chk("R5 fill lowest free", int'(w_f), b);
    end
    issue(0); chk("R8 hit w0", int'(h_f), 1); chk("R3 way0", int'(w_f), 0);
    issue(1); chk("R8 hit w1", int'(h_f), 1); chk("R3 way1", int'(w_f), 1);
    issue(5); chk("R6 miss", int'(h_f), 0); chk("R6 victim", int'(w_f), ways[0]);
    issue(2); chk("R6 miss", int'(h_f), 0); chk("R6 victim", int'(w_f), ways[1]);
    issue(0); chk("R6 hit", int'(h_f), 1); chk("R6 way", int'(w_f), ways[2]);
    issue(3); chk("R6 miss", int'(h_f), 0); chk("R6 victim", int'(w_f), ways[3]);
  endtask

  task automatic t_direct();
    int hits [6] = '{0, 0, 1, 1, 0, 0};
    int blks [6] = '{0, 1, 0, 1, 2, 0};
    do_flush();
    for (int i = 0; i < 6; i++) begin
      issue(blks[i]);
      chk("R7 direct-mapped hit", int'(h_d), hits[i]);
      chk("R7 direct-mapped way", int'(w_d), 0);
    end
  endtask

  task automatic t_flush();
    do_flush();
    exp_a("R10 prefill", 0, 0, 0);
    exp_a("R10 prefill hit", 0, 1, 0);
    @(negedge clk);
    flush = 1'b1;
    req_valid = 1'b1;
    req_blk = 8'd0;
    #1;
    chk("R10 req_ready low in flush", int'(rdy_a), 0);
    @(negedge clk);
    chk("R10 no response for refused request", int'(v_a), 0);
    flush = 1'b0;
    req_valid = 1'b0;
    exp_a("R10 miss after flush", 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_pingpong();
    t_sets();
    t_lru();
    t_fully();
    t_direct();
    t_flush();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule